// File: doc/BRIEF.md
# Brown-out Reset Conditioning Controller

This block is a synchronous reset supervisor. It watches a digitized supply-good flag, which comes from an analog comparator outside the block. It also samples two external reset pins, one active high and one active low. From these it produces a single reset decision. That decision drives two reset outputs of opposite polarity in lockstep, each with an open-drain style drive enable.

While the supply is below its trip point, reset is asserted at once, with no clock delay. When the supply recovers, reset stays asserted for a programmable number of clock cycles. A rising edge on the active-high pin, or a falling edge on the active-low pin, also starts that full timeout. Such an edge reloads the timeout if one is already running.

The two pins are shared with the outputs. The block therefore ignores the pin transition that its own assertion produces, so that asserting reset cannot keep extending reset. Each pin passes through a synchronizer before edge detection. The timeout length `TICKS` is counted in clock cycles. At the default value, 25,000,000 cycles at 125 MHz give the nominal 200 ms.

Top module: `brownout_rst_sup`

## Requirements
- R1: While `supply_ok_i` is 0, reset is asserted on every cycle.
- R2: When `supply_ok_i` falls, reset is asserted in that same cycle, without waiting for a clock edge.
- R3: After `supply_ok_i` returns to 1, reset stays asserted after each of the next `TICKS`-1 rising clock edges. It is released after the `TICKS`-th edge.
- R4: A 0-to-1 transition on `ext_rst_i` asserts reset from the third rising edge after the change, for exactly `TICKS` edges.
- R5: A 1-to-0 transition on `ext_rst_ni` asserts reset from the third rising edge after the change, for exactly `TICKS` edges.
- R6: A 1-to-0 transition on `ext_rst_i`, a 0-to-1 transition on `ext_rst_ni` and steady pin levels never assert reset.
- R7: When reset is asserted: `rst_hi_o`=1, `rst_lo_no`=0 and both enables are 1. When reset is released: `rst_hi_o`=0, `rst_lo_no`=1 and both enables are 0.
- R8: A qualifying pin edge during a running timeout reloads the full `TICKS` count, measured from that edge's own three-edge latency.
- R9: A supply drop during a running timeout holds reset until the supply recovers. A full R3 timeout then follows.
- R10: A pin transition caused by the block's own assertion, arriving `SYNC_STAGES` edges later, neither starts nor extends a timeout.
- R11: While `rst_ni` is 0, reset is asserted. After `rst_ni` is released with the supply good, reset releases as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Supply at or above trip point (synchronous) |
| ext_rst_i | input | 1 | Sampled level of the active-high reset pin |
| ext_rst_ni | input | 1 | Sampled level of the active-low reset pin |
| rst_hi_o | output | 1 | Active-high reset level |
| rst_hi_oe_o | output | 1 | Drive enable for the active-high pin (drives high only) |
| rst_lo_no | output | 1 | Active-low reset level |
| rst_lo_oe_o | output | 1 | Drive enable for the active-low pin (pulls low only) |

## Verification
The hardest case to reach from the ports is the block seeing its own drive come back on the pins two cycles later. An unmasked echo would look exactly like an external edge. To reach it, the bench wires each pin back to the block's own enable, as on a board. It then drops the supply for one cycle, so that the echo arrives after recovery, inside the timeout, where an unmasked echo would reload the counter. Exact release timing is then measured against the three-edge pin latency and the `TICKS` count, including reloads and supply drops in mid-timeout.

// File: rtl/rst_sup_pkg.sv
package rst_sup_pkg;
  localparam int unsigned NUM_TRIG = 2;
  typedef enum logic [0:0] {
    TRIG_HI = 1'b0,
    TRIG_LO = 1'b1
  } trig_ch_e;
endpackage

// File: rtl/rst_sup_sync.sv
module rst_sup_sync #(
  parameter int unsigned STAGES = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[0] <= RST_VAL;
        else         stage_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rst_sup_edge_qual.sv
module rst_sup_edge_qual #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,   // normalized: 1 = pin in asserted state
  input  logic own_i,   // block is driving reset this cycle
  output logic trig_o
);
  localparam int unsigned OW = SYNC_STAGES + 1;

  logic          pin_s;
  logic          prev_q;
  logic [OW-1:0] own_q;
  logic          rise;
  logic          own_echo;

  // reset to the asserted level: the block drives reset while in reset
  rst_sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      own_q  <= '1;
    end else begin
      prev_q <= pin_s;
      own_q  <= {own_q[OW-2:0], own_i};
    end
  end

  assign rise = pin_s & ~prev_q;
  // own assertion reaches pin_s after SYNC_STAGES edges; align and cancel it
  assign own_echo = own_q[SYNC_STAGES-1] & ~own_q[SYNC_STAGES];
  assign trig_o   = rise & ~own_echo;

  // R4
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);
endmodule

// File: rtl/rst_sup_timer.sv
module rst_sup_timer #(
  parameter int unsigned TICKS = 25_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] FULL = CW'(TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= FULL;
    else if (load_i)        cnt_q <= FULL;
    else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);

  // R8
  reload_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == FULL);

  // R3
  count_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !load_i) |=> cnt_q == $past(cnt_q) - CW'(1));
endmodule

// File: rtl/brownout_rst_sup.sv
module brownout_rst_sup #(
  parameter int unsigned TICKS       = 25_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic ext_rst_i,
  input  logic ext_rst_ni,
  output logic rst_hi_o,
  output logic rst_hi_oe_o,
  output logic rst_lo_no,
  output logic rst_lo_oe_o
);
  import rst_sup_pkg::*;

  logic [NUM_TRIG-1:0] pin_norm;
  logic [NUM_TRIG-1:0] trig;
  logic                busy;
  logic                rst_act;
  logic                load;

  assign pin_norm[TRIG_HI] = ext_rst_i;
  assign pin_norm[TRIG_LO] = ~ext_rst_ni;

  for (genvar c = 0; c < NUM_TRIG; c++) begin : g_trig
    rst_sup_edge_qual #(.SYNC_STAGES(SYNC_STAGES)) u_qual (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (pin_norm[c]),
      .own_i (rst_act),
      .trig_o(trig[c])
    );
  end

  assign load = ~supply_ok_i | (|trig);

  rst_sup_timer #(.TICKS(TICKS)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .busy_o(busy)
  );

  // supply path is combinational: no edge between brown-out and reset
  assign rst_act     = ~supply_ok_i | busy;
  assign rst_hi_o    = rst_act;
  assign rst_hi_oe_o = rst_act;
  assign rst_lo_no   = ~rst_act;
  assign rst_lo_oe_o = rst_act;

  // R1
  low_supply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |-> rst_hi_oe_o && rst_lo_oe_o && !rst_lo_no);

  // R2
  drop_now_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(supply_ok_i) |-> rst_hi_o && rst_lo_oe_o);

  // R9
  recover_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> rst_hi_oe_o);

  // R4
  edge_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|trig) |=> rst_hi_oe_o && !rst_lo_no);
endmodule

// File: tb/brownout_rst_sup_bench.sv
module brownout_rst_sup_bench;
  localparam int T = 6;
  localparam int EV_HI_RISE = 0, EV_HI_FALL = 1, EV_LO_FALL = 2, EV_LO_RISE = 3, EV_SUP = 4;
  localparam int NV = 5;
  localparam int V_EV  [NV] = '{EV_HI_RISE, EV_HI_FALL, EV_LO_FALL, EV_LO_RISE, EV_SUP};
  localparam int V_LAT [NV] = '{3, -1, 3, -1, 1};
  localparam int V_LEN [NV] = '{T, 0, T, 0, T - 1};

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic supply_ok_i = 1'b1;
  logic drv_hi = 1'b0, drv_lo = 1'b1, loop_en = 1'b0;
  logic ext_rst_i, ext_rst_ni;
  logic rst_hi_o, rst_hi_oe_o, rst_lo_no, rst_lo_oe_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  assign ext_rst_i  = drv_hi | (loop_en & rst_hi_oe_o);
  assign ext_rst_ni = drv_lo & ~(loop_en & rst_lo_oe_o);

  brownout_rst_sup #(.TICKS(T), .SYNC_STAGES(2)) u_brownout_rst_sup (
    .clk_i(clk_i), .rst_ni(rst_ni), .supply_ok_i(supply_ok_i),
    .ext_rst_i(ext_rst_i), .ext_rst_ni(ext_rst_ni),
    .rst_hi_o(rst_hi_o), .rst_hi_oe_o(rst_hi_oe_o),
    .rst_lo_no(rst_lo_no), .rst_lo_oe_o(rst_lo_oe_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R7: level/enable pairing and lockstep on every sample
  task automatic chk_pins;
    logic [3:0] got;
    logic [3:0] want;
    got  = {rst_hi_o, rst_hi_oe_o, rst_lo_no, rst_lo_oe_o};
    want = rst_hi_oe_o ? 4'b1101 : 4'b0010;
    check(got == want, "R7 pins", int'(got), int'(want));
  endtask

  task automatic observe(input int n, output int first, output int last, output int cnt);
    first = -1; last = -1; cnt = 0;
    for (int j = 1; j <= n; j++) begin
      @(posedge clk_i); #1;
      chk_pins();
      if (rst_hi_oe_o) begin
        if (first < 0) first = j;
        last = j;
        cnt++;
      end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
  endtask

  task automatic run_vec(input int ev, input int lat, input int len);
    int first, last, cnt;
    string req;
    @(negedge clk_i);
    case (ev)
      EV_HI_RISE: begin drv_hi = 1'b1; req = "R4"; end
      EV_HI_FALL: begin drv_hi = 1'b0; req = "R6"; end
      EV_LO_FALL: begin drv_lo = 1'b0; req = "R5"; end
      EV_LO_RISE: begin drv_lo = 1'b1; req = "R6"; end
      default: begin
        req = "R3";
        supply_ok_i = 1'b0;
        #1;
        check(rst_hi_oe_o == 1'b1, "R2 immediate", int'(rst_hi_oe_o), 1);
        for (int k = 0; k < 3; k++) begin
          @(posedge clk_i); #1;
          check(rst_hi_oe_o == 1'b1, "R1 held low", int'(rst_hi_oe_o), 1);
        end
        @(negedge clk_i);
        supply_ok_i = 1'b1;
      end
    endcase
    observe(T + 8, first, last, cnt);
    check(first == lat, {req, " latency"}, first, lat);
    check(cnt == len, {req, " length"}, cnt, len);
    idle(3);
  endtask

  initial begin
    int first, last, cnt;
    // R11: reset state
    idle(3);
    #1;
    check(rst_hi_oe_o && rst_lo_oe_o && !rst_lo_no && rst_hi_o, "R11 in reset",
          int'(rst_hi_oe_o), 1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    observe(T + 4, first, last, cnt);
    check(last == T - 1, "R11 release", last, T - 1);
    check(rst_hi_o == 1'b0 && rst_lo_no == 1'b1, "R7 released", int'(rst_hi_o), 0);

    for (int v = 0; v < NV; v++) run_vec(V_EV[v], V_LAT[v], V_LEN[v]);

    // R8: lo-pin edge during hi-pin timeout reloads
    drv_hi = 1'b0; drv_lo = 1'b1; idle(4);
    @(negedge clk_i); drv_hi = 1'b1;
    observe(4, first, last, cnt);
    @(negedge clk_i); drv_lo = 1'b0;
    observe(16, first, last, cnt);
    check(last == 8, "R8 reload release", last + 4, 12);

    // R9: supply drop mid-timeout restarts full count after recovery
    drv_hi = 1'b0; drv_lo = 1'b1; idle(6);
    @(negedge clk_i); drv_hi = 1'b1;
    observe(4, first, last, cnt);
    @(negedge clk_i); supply_ok_i = 1'b0;
    observe(3, first, last, cnt);
    check(cnt == 3, "R9 held during drop", cnt, 3);
    @(negedge clk_i); supply_ok_i = 1'b1;
    observe(T + 6, first, last, cnt);
    check(last == T - 1, "R9 restart", last, T - 1);

    // R10: pins wired back to own drive; one-cycle brown-out
    drv_hi = 1'b0; drv_lo = 1'b1; idle(6);
    loop_en = 1'b1;
    idle(4);
    @(negedge clk_i); supply_ok_i = 1'b0;
    #1;
    check(ext_rst_i == 1'b1 && ext_rst_ni == 1'b0, "R10 loopback drive", int'(ext_rst_i), 1);
    @(negedge clk_i); supply_ok_i = 1'b1;
    observe(T + 10, first, last, cnt);
    check(last == T - 1, "R10 no self extend", last, T - 1);
    check(cnt == T - 1, "R10 no self retrigger", cnt, T - 1);
    loop_en = 1'b0;

    // R6: steady levels hold no reset
    observe(8, first, last, cnt);
    check(cnt == 0, "R6 steady", cnt, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule